// File: doc/BRIEF.md
# Per-Pin GPIO Control Bank

A bank of 32 general-purpose pins. Each pin has one byte-wide control register on a simple synchronous register bus. The bus has an address, a write strobe, a read strobe, write data and registered read data. Through its register, each pin can be set up in one of three ways:

- As an input. The input path has a polarity choice, an optional debounce filter and a sticky event flag.
- As a driven output. The output carries a fixed level or one of two clock sources.
- As an alternate function. The pad controls then come from per-pin alternate-function inputs.

Pad inputs are resynchronised through two flops. The conditioned input level of every pin is available on `in_value`. Per-pin output enable and output value go toward the pads.

Software uses the bank by writing a control byte to one pin at a time. It reads the same byte back to see the live pin level and the event flag. It clears the event flag by writing a one to that bit.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin register reads 0x00 (the pin level bit reflects a low pin), `pad_oe` is all zero and `pad_out` is all zero.
- R2: Pin i is controlled by the register at address 0x10+i. Read data appears on `bus_rdata` in the cycle after the read strobe. Reads of addresses outside 0x10..0x2F return 0x00, and writes to them change no register.
- R3: Register bits 4:0 read back as written. Bit 7 always reads 0. Bit 5 is read-only and shows the pin level after the two-flop synchronizer. Writes to bits 7 and 5 have no effect.
- R4: Bits 3:2 select the mode.
  - 00 is input: `pad_oe` is low and `pad_out` is low.
  - 01 is output: `pad_oe` is high.
  - 10 and 11 are alternate function: `pad_oe` and `pad_out` copy `alt_oe` and `alt_out` of that pin.
- R5: In output mode, bits 1:0 select what `pad_out` carries:
  - 00 drives 0.
  - 01 drives 1.
  - 10 passes `clk_src0`.
  - 11 passes `clk_src1`.
- R6: Bit 0 selects the input polarity. When it is 1, the pin is active while its filtered level is high. When it is 0, the pin is active while that level is low. With bit 1 clear, `in_value` shows the active state.
- R7: Bit 6 is a sticky event flag.
  - It sets on the clock edge after the pin becomes active.
  - It stays set until a write with bit 6 = 1. A write with bit 6 = 0 leaves it set.
  - When a new event and a clearing write meet on the same edge, the flag ends set.
- R8: With bit 4 set, a new input level is taken only after 4 consecutive `sample_en` strobes during which the synchronized level differs from the held one. A return to the held level restarts that count. With bit 4 clear, the filter passes the synchronized level directly.
- R9: With bit 1 set, `in_value` shows the sticky event flag instead of the live active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | 32 | Raw pad input levels |
| sample_en | input | 1 | Debounce sample strobe |
| clk_src0 | input | 1 | First clock source for output mode |
| clk_src1 | input | 1 | Second clock source for output mode |
| alt_oe | input | 32 | Alternate-function output enables |
| alt_out | input | 32 | Alternate-function output values |
| pad_oe | output | 32 | Output enable per pad |
| pad_out | output | 32 | Output value per pad |
| in_value | output | 32 | Conditioned input per pin |

## Verification
Every in-range register is written with a distinct per-pin byte that has bits 7 and 5 set. Every out-of-range address is written with 0xFF and read back. Together these separate a wrong decode, a missing write mask and a leaking write.

Two complementary pin-level patterns are applied against a fixed polarity pattern across all 32 pins, so that an inverted or swapped polarity shows up on single bits.

The output multiplexer is swept over all four sub-field codes and all four clock-source combinations, and both alternate-mode codes are swept over all four enable/value combinations.

The debounce filter is given exactly three and then four strobes. It is also given an interrupted run, which tells a counter that restarts apart from one that only accumulates. The event flag is driven with a clearing write on the very edge of a new event.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPINS    = 32,
  parameter int ADDR_W   = 8,
  parameter int BASE     = 16,
  parameter int DB_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              sample_en,
  input  logic              clk_src0,
  input  logic              clk_src1,
  input  logic [NPINS-1:0]  alt_oe,
  input  logic [NPINS-1:0]  alt_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  in_value
);
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int CW = (DB_COUNT > 1) ? $clog2(DB_COUNT) : 1;
  localparam int LO = BASE;
  localparam int HI = BASE + NPINS;

  logic [NPINS-1:0][4:0]    cfg;
  logic [NPINS-1:0][CW-1:0] dbc;
  logic [NPINS-1:0] s1, s2, dbq, act, actq, lat;
  logic [IW-1:0]    idx;
  logic             in_range;
  logic [7:0]       rsel;
  logic             unused_wbits;

  assign unused_wbits = ^{bus_wdata[7], bus_wdata[5]};
  assign in_range = (int'(bus_addr) >= LO) && (int'(bus_addr) < HI);
  assign idx      = IW'(bus_addr - ADDR_W'(BASE));
  assign rsel     = {1'b0, lat[idx], s2[idx], cfg[idx]};

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      act[i]      = cfg[i][0] ? (cfg[i][4] ? dbq[i] : s2[i]) : ~(cfg[i][4] ? dbq[i] : s2[i]);
      in_value[i] = cfg[i][1] ? lat[i] : act[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1        <= '0;
      s2        <= '0;
      dbq       <= '0;
      dbc       <= '0;
      actq      <= '1;
      lat       <= '0;
      cfg       <= '0;
      bus_rdata <= '0;
    end else begin
      s1   <= pin_in;
      s2   <= s1;
      actq <= act;
      if (bus_rd) bus_rdata <= in_range ? rsel : 8'h00;
      for (int i = 0; i < NPINS; i++) begin
        if (bus_wr && in_range && idx == IW'(i)) cfg[i] <= bus_wdata[4:0];
        if (act[i] && !actq[i]) lat[i] <= 1'b1;
        else if (bus_wr && in_range && idx == IW'(i) && bus_wdata[6]) lat[i] <= 1'b0;
        if (!cfg[i][4] || s2[i] == dbq[i]) begin
          dbq[i] <= s2[i];
          dbc[i] <= '0;
        end else if (sample_en) begin
          if (dbc[i] == CW'(DB_COUNT - 1)) begin
            dbq[i] <= s2[i];
            dbc[i] <= '0;
          end else begin
            dbc[i] <= dbc[i] + 1'b1;
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    logic osel;
    assign osel       = cfg[i][1] ? (cfg[i][0] ? clk_src1 : clk_src0) : cfg[i][0];
    assign pad_oe[i]  = cfg[i][3] ? alt_oe[i] : cfg[i][2];
    assign pad_out[i] = cfg[i][3] ? alt_out[i] : (cfg[i][2] & osel);

    p_latch_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lat[i] && !(bus_wr && in_range && idx == IW'(i) && bus_wdata[6])) |=> lat[i]);
    p_oe_only_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[i] |-> (cfg[i][3:2] != 2'b00));
    p_db_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[i][4] && !sample_en) |=> $stable(dbq[i]));
  end

  p_oor_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !in_range) |=> bus_rdata == 8'h00);
  p_oor_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !in_range) |=> $stable(cfg));
  p_top_bit_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rdata[7]);
endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic bus_wr = 0, bus_rd = 0, sample_en = 0, clk_src0 = 0, clk_src1 = 0;
  logic [31:0] pin_in = 0, alt_oe = 0, alt_out = 0;
  logic [7:0] bus_rdata;
  logic [31:0] pad_oe, pad_out, in_value;
  int errors = 0, checks = 0;

  gpio_bank uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .sample_en(sample_en),
    .clk_src0(clk_src0), .clk_src1(clk_src1), .alt_oe(alt_oe), .alt_out(alt_out),
    .pad_oe(pad_oe), .pad_out(pad_out), .in_value(in_value));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int n);
    repeat (n) begin
      @(negedge clk); sample_en = 1;
      @(negedge clk); sample_en = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [31:0] pp, qq;
    wait_n(3); rst_n = 1; wait_n(1);

    // R1: reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    for (int i = 0; i < 32; i++) begin
      rd_reg(8'(16 + i), d);
      check("R1 reset value", {24'h0, d}, 32'h0);
    end

    // R3: live level bit
    pp = 32'h3C5A_96F0;
    pin_in = pp; wait_n(3);
    for (int i = 0; i < 32; i++) begin
      rd_reg(8'(16 + i), d);
      check("R3 level bit", {24'h0, d}, {26'h0, pp[i], 5'h0});
    end
    pin_in = 0; wait_n(4);

    // R2 R3: address map and write mask
    for (int i = 0; i < 32; i++) begin
      wr_reg(8'(16 + i), 8'hE0 | 8'((i * 7 + 3) & 31));
      rd_reg(8'(16 + i), d);
      check("R3 readback mask", {24'h0, d}, 32'((i * 7 + 3) & 31));
    end
    for (int a = 0; a < 256; a++) begin
      if (a >= 16 && a < 48) continue;
      wr_reg(8'(a), 8'hFF);
      rd_reg(8'(a), d);
      check("R2 out-of-range read", {24'h0, d}, 32'h0);
    end
    for (int i = 0; i < 32; i++) begin
      rd_reg(8'(16 + i), d);
      check("R2 no leak from out-of-range write", {24'h0, d}, 32'((i * 7 + 3) & 31));
    end

    // R6: polarity across all pins
    qq = 32'hA5C3_0F96;
    for (int i = 0; i < 32; i++) wr_reg(8'(16 + i), 8'h40 | {7'h0, qq[i]});
    pin_in = pp; wait_n(3);
    check("R6 polarity pattern A", in_value, ~(pp ^ qq));
    check("R4 input mode oe", pad_oe, 32'h0);
    pin_in = ~pp; wait_n(3);
    check("R6 polarity pattern B", in_value, ~(~pp ^ qq));
    pin_in = 0; wait_n(4);

    // R7: sticky flag on pin 5
    wr_reg(8'h15, 8'h41); rd_reg(8'h15, d);
    check("R7 cleared", {24'h0, d}, 32'h01);
    pin_in[5] = 1; wait_n(4); rd_reg(8'h15, d);
    check("R7 set on event", {24'h0, d}, 32'h61);
    pin_in[5] = 0; wait_n(4); rd_reg(8'h15, d);
    check("R7 sticky", {24'h0, d}, 32'h41);
    wr_reg(8'h15, 8'h01); rd_reg(8'h15, d);
    check("R7 write zero no effect", {24'h0, d}, 32'h41);
    wr_reg(8'h15, 8'h41); rd_reg(8'h15, d);
    check("R7 write one clears", {24'h0, d}, 32'h01);

    // R9: latched selection
    wr_reg(8'h15, 8'h03); wait_n(1);
    check("R9 latched view clear", {31'h0, in_value[5]}, 32'h0);
    pin_in[5] = 1; wait_n(4); pin_in[5] = 0; wait_n(4);
    check("R9 latched view held", {31'h0, in_value[5]}, 32'h1);

    // R7: set wins over clear on the same edge
    wr_reg(8'h15, 8'h41); wait_n(2);
    @(negedge clk); pin_in[5] = 1;
    @(negedge clk);
    wr_reg(8'h15, 8'h41);
    rd_reg(8'h15, d);
    check("R7 set beats clear", {24'h0, d}, 32'h61);
    wr_reg(8'h15, 8'h41); rd_reg(8'h15, d);
    check("R7 clear without event", {24'h0, d}, 32'h21);
    pin_in[5] = 0;

    // R8: debounce on pin 7
    wr_reg(8'h17, 8'h51); wait_n(3);
    check("R8 initial", {31'h0, in_value[7]}, 32'h0);
    pin_in[7] = 1; wait_n(3); strobe(3);
    check("R8 three strobes not enough", {31'h0, in_value[7]}, 32'h0);
    strobe(1);
    check("R8 fourth strobe accepts", {31'h0, in_value[7]}, 32'h1);
    pin_in[7] = 0; wait_n(3); strobe(3);
    pin_in[7] = 1; wait_n(3);
    pin_in[7] = 0; wait_n(3); strobe(3);
    check("R8 count restarts after bounce", {31'h0, in_value[7]}, 32'h1);
    strobe(1);
    check("R8 release accepted", {31'h0, in_value[7]}, 32'h0);

    // R4 R5: output mux on pin 9
    for (int s = 0; s < 4; s++) begin
      wr_reg(8'h19, 8'h04 | 8'(s));
      for (int c = 0; c < 4; c++) begin
        @(negedge clk); clk_src0 = c[0]; clk_src1 = c[1]; #1;
        check("R4 output oe", pad_oe, 32'h200);
        check("R5 output value", {31'h0, pad_out[9]},
              {31'h0, (s == 0) ? 1'b0 : (s == 1) ? 1'b1 : (s == 2) ? c[0] : c[1]});
      end
    end

    // R4: alternate function on pin 9
    for (int m = 2; m < 4; m++) begin
      wr_reg(8'h19, 8'(m << 2));
      for (int c = 0; c < 4; c++) begin
        @(negedge clk); alt_oe = {32{c[0]}}; alt_out = {32{c[1]}}; #1;
        check("R4 alt oe", {31'h0, pad_oe[9]}, {31'h0, c[0]});
        check("R4 alt out", {31'h0, pad_out[9]}, {31'h0, c[1]});
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule